// File: doc/BRIEF.md
# LCD Line Timer

This block produces the line and frame timing skeleton for a small tile-based LCD controller. A dot-clock enable advances it one dot at a time. Each visible line is split into three phases of unequal length: an object-table search, a video-memory transfer and a horizontal blank. After the visible lines, a run of whole lines forms the vertical blank. The block does not fetch pixels. It reports the current phase as a 2-bit mode code and the current line number. It also gives single-cycle markers at three points: when horizontal blank begins, when vertical blank begins, and when a new frame starts.

The rest of the controller decodes the mode code and the markers. It uses them to gate memory access and to raise interrupts. All outputs are registered. Every counter and every output freezes while the dot enable is low.

Top module: `lcd_line_timer`

## Requirements
- R1: After a synchronous reset the line is 0, the mode is search (code 2) at dot 0, and all three markers are low.
- R2: Mode codes are fixed: hblank = 0, vblank = 1, search = 2, transfer = 3. On a visible line, search covers dots 0 to 79.
- R3: Transfer (code 3) covers dots 80 to 251 of a visible line. It always follows search directly.
- R4: Hblank (code 0) covers dots 252 to 455. A line is 456 dots, and the line number steps up on the dot after 455.
- R5: Lines 0 to 143 are visible. Lines 144 to 153 are vblank (code 1) for the whole line, and the line number keeps counting through them.
- R6: After line 153 the block returns to line 0 in search. One frame is 70224 enabled cycles.
- R7: The hblank marker is high for exactly the one enabled cycle in which a visible line enters hblank. It never fires during vblank.
- R8: The vblank marker is high for exactly the one enabled cycle in which line 144 begins in mode 1.
- R9: The frame marker is high for exactly the one enabled cycle in which line 0 begins after line 153. Reset does not raise it.
- R10: While the dot enable is low, mode, line and all markers hold their values, including a marker that is high.
- R11: Reset takes priority over the dot enable at any point in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dot_en | input | 1 | Dot-clock enable; one dot per high cycle |
| mode_o | output | 2 | Current mode code |
| line_o | output | LINE_W | Current line number |
| hblank_o | output | 1 | Horizontal blank entry marker |
| vblank_o | output | 1 | Vertical blank entry marker |
| frame_o | output | 1 | Frame start marker |

## Verification
Two events can fall in the same cycle, and both are tested.

The first is a marker and a frozen enable. The bench drops the dot enable on the exact cycle the hblank marker is high. The marker must stay high, with mode and line unchanged, until dots resume. It must then clear on the very next enabled cycle.

The second is the frame wrap. Here the line number rolls over, mode 1 changes to mode 2, and the frame marker rises, all on one edge. The bench samples that single edge and requires all three results together.

A reset during a later line is also judged against the reset state.

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int SEARCH_DOTS = 80,
  parameter int XFER_DOTS   = 172,
  parameter int HBLANK_DOTS = 204,
  parameter int VIS_LINES   = 144,
  parameter int VBL_LINES   = 10,
  parameter int LINE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dot_en,
  output logic [1:0]        mode_o,
  output logic [LINE_W-1:0] line_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              frame_o
);
  localparam int LINE_DOTS = SEARCH_DOTS + XFER_DOTS + HBLANK_DOTS;
  localparam int ALL_LINES = VIS_LINES + VBL_LINES;
  localparam int DW        = $clog2(LINE_DOTS);

  localparam logic [1:0] M_HBL  = 2'd0;
  localparam logic [1:0] M_VBL  = 2'd1;
  localparam logic [1:0] M_SRCH = 2'd2;
  localparam logic [1:0] M_XFER = 2'd3;

  localparam logic [DW-1:0]     D_LAST = DW'(LINE_DOTS - 1);
  localparam logic [DW-1:0]     D_XFER = DW'(SEARCH_DOTS);
  localparam logic [DW-1:0]     D_HBL  = DW'(SEARCH_DOTS + XFER_DOTS);
  localparam logic [LINE_W-1:0] L_VIS  = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] L_VEND = LINE_W'(VIS_LINES - 1);
  localparam logic [LINE_W-1:0] L_LAST = LINE_W'(ALL_LINES - 1);

  logic [DW-1:0]     dot_q, dot_n;
  logic [LINE_W-1:0] line_n;
  logic [1:0]        mode_n;
  logic              eol, last_line;

  assign eol       = (dot_q == D_LAST);
  assign last_line = (line_o == L_LAST);
  assign dot_n     = eol ? '0 : dot_q + 1'b1;
  assign line_n    = !eol ? line_o : (last_line ? '0 : line_o + 1'b1);

  always_comb begin
    if (line_n >= L_VIS)      mode_n = M_VBL;
    else if (dot_n < D_XFER)  mode_n = M_SRCH;
    else if (dot_n < D_HBL)   mode_n = M_XFER;
    else                      mode_n = M_HBL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dot_q    <= '0;
      line_o   <= '0;
      mode_o   <= M_SRCH;
      hblank_o <= 1'b0;
      vblank_o <= 1'b0;
      frame_o  <= 1'b0;
    end else if (dot_en) begin
      dot_q    <= dot_n;
      line_o   <= line_n;
      mode_o   <= mode_n;
      hblank_o <= (dot_n == D_HBL) && (line_n < L_VIS);
      vblank_o <= eol && (line_o == L_VEND);
      frame_o  <= eol && last_line;
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !dot_en |=> $stable({mode_o, line_o, hblank_o, vblank_o, frame_o}));

  p_search_then_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    (dot_en && mode_o == M_SRCH) |=> (mode_o == M_SRCH || mode_o == M_XFER));

  p_markers_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hblank_o, vblank_o, frame_o}));

  p_hbl_in_mode0_r7: assert property (@(posedge clk) disable iff (rst)
    hblank_o |-> (mode_o == M_HBL));

  p_vbl_entry_r8: assert property (@(posedge clk) disable iff (rst)
    vblank_o |-> (mode_o == M_VBL && line_o == L_VIS));

  p_frame_entry_r9: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> (mode_o == M_SRCH && line_o == '0));

  p_line_range_r5: assert property (@(posedge clk) disable iff (rst)
    line_o <= L_LAST);
endmodule

// File: tb/test_lcd_line_timer.sv
`timescale 1ns/1ps
module test_lcd_line_timer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dot_en = 1'b0;
  logic [1:0] mode_o;
  logic [7:0] line_o;
  logic hblank_o, vblank_o, frame_o;

  int checks = 0;
  int errors = 0;
  int k = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_line_timer i_lcd_line_timer (
    .clk(clk), .rst(rst), .dot_en(dot_en), .mode_o(mode_o), .line_o(line_o),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .frame_o(frame_o));

  function automatic int e_pos(int n); return n % 456; endfunction
  function automatic int e_line(int n); return (n / 456) % 154; endfunction
  function automatic int e_mode(int n);
    if (e_line(n) >= 144) return 1;
    if (e_pos(n) < 80) return 2;
    if (e_pos(n) < 252) return 3;
    return 0;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at dot %0d: got %0d expected %0d", req, k, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, mode_o, e_mode(k));
    chk(req, line_o, e_line(k));
    chk(req, hblank_o, int'(e_pos(k) == 252 && e_line(k) < 144));
    chk(req, vblank_o, int'(e_pos(k) == 0 && e_line(k) == 144));
    chk(req, frame_o, int'(k > 0 && e_pos(k) == 0 && e_line(k) == 0));
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_to(int target);
    dot_en = 1'b1;
    while (k < target) begin tick(); k++; end
  endtask

  task automatic t_reset();
    rst = 1'b1; dot_en = 1'b1;
    tick(); tick();
    rst = 1'b0; k = 0;
    chk("R1 mode", mode_o, 2); chk("R1 line", line_o, 0);
    chk("R1 markers", {hblank_o, vblank_o, frame_o}, 0);
  endtask

  task automatic t_first_line();
    run_to(79);  chk_all("R2 search end");
    run_to(80);  chk_all("R3 transfer start"); chk("R3", mode_o, 3);
    run_to(251); chk_all("R3 transfer end");
    run_to(252); chk_all("R4 hblank start"); chk("R7 pulse", hblank_o, 1);
    run_to(253); chk("R7 single", hblank_o, 0);
    run_to(455); chk_all("R4 line end");
    run_to(456); chk_all("R4 next line"); chk("R4 line", line_o, 1);
  endtask

  task automatic t_hold();
    run_to(456 + 252); chk("R7 line1", hblank_o, 1);
    dot_en = 1'b0;
    for (int i = 0; i < 7; i++) begin
      tick();
      chk("R10 hold marker", hblank_o, 1);
      chk("R10 hold mode", mode_o, 0);
      chk("R10 hold line", line_o, 1);
    end
    dot_en = 1'b1; tick(); k++;
    chk_all("R10 resume"); chk("R10 marker clears", hblank_o, 0);
  endtask

  task automatic t_vblank();
    run_to(65663); chk_all("R5 last visible");
    run_to(65664); chk_all("R8 vblank entry"); chk("R8 pulse", vblank_o, 1);
    chk("R5 line", line_o, 144);
    run_to(65665); chk("R8 single", vblank_o, 0);
    run_to(65664 + 252); chk_all("R7 no hblank in vblank"); chk("R7", hblank_o, 0);
    run_to(153 * 456); chk_all("R5 line 153"); chk("R5 mode", mode_o, 1);
  endtask

  task automatic t_frame();
    run_to(70223); chk_all("R6 frame end");
    run_to(70224); chk_all("R6 wrap");
    chk("R9 pulse", frame_o, 1); chk("R6 line", line_o, 0); chk("R6 mode", mode_o, 2);
    run_to(70225); chk("R9 single", frame_o, 0);
    run_to(70224 + 252); chk_all("R7 second frame");
  endtask

  task automatic t_midreset();
    run_to(70224 + 3 * 456 + 100);
    rst = 1'b1; dot_en = 1'b1; tick(); rst = 1'b0; k = 0;
    chk("R11 line", line_o, 0); chk("R11 mode", mode_o, 2);
    chk("R9 no frame on reset", frame_o, 0);
    run_to(1); chk_all("R11 restart");
  endtask

  initial begin
    t_reset();
    t_first_line();
    t_hold();
    t_vblank();
    t_frame();
    t_midreset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule